// File: doc/BRIEF.md
# OVSF Code-Tree Occupancy Guard

This block keeps the record of which orthogonal variable spreading factor codes are in use inside one cell and decides whether a new code may be handed out without breaking orthogonality. Each code is named by the base-2 logarithm of its spreading factor (0 for SF 1 up to 9 for SF 512) and by an index that runs from 0 to SF-1. In the code tree, a code of length 2^d has two children of length 2^(d+1): the parent repeated, and the parent followed by its own negation. Two codes clash when one of them lies on the other's path to the root. Codes with the same spreading factor and different indices never clash.

A request carries an opcode, a code and a valid strobe. The opcode selects one of three actions. A query only reports whether the code is free. An assign reserves the code in a free table slot. A release frees a slot that holds exactly that code. Every request is compared against all live table entries at once. One cycle after acceptance, the block returns one outcome flag together with a slot number. Generating the chips and choosing codes are left to the surrounding logic.

Top module: `ovsf_tree_guard`

## Requirements
- R1: `req_ready` is always high. Every accepted request produces `rsp_valid` exactly one clock later, and an idle cycle produces none. In each response exactly one of grant, conflict, full and error is set.
- R2: For log values a <= b, the codes (a, ka) and (b, kb) clash when floor(kb / 2^(b-a)) = ka. This includes an identical code. A query on a clashing code returns conflict. A query on a non-clashing code returns grant with slot 0.
- R3: While SF 4 index 1 is held, the following report conflict: SF 1 index 0, SF 2 index 0, SF 8 indices 2 and 3, and SF 16 indices 4 to 7. SF 4 indices 0, 2 and 3 report grant.
- R4: An assign of a legal, non-clashing code with a free slot returns grant. The slot field gives the lowest-numbered free slot, and the code is stored there.
- R5: An assign or query that clashes returns conflict. The slot field gives the lowest-numbered live entry that clashes, and the table is left unchanged.
- R6: An assign that clashes with nothing but finds every slot occupied returns full, and the table is left unchanged. A clash takes priority over full.
- R7: A release whose code matches a live entry in both log and index returns grant with that slot and frees it. Any other release, including one naming an ancestor or a descendant, returns error and changes nothing.
- R8: A request is rejected with error and no table change in any of these cases: opcode 2'b11 (the encodings are 2'b00 query, 2'b01 assign, 2'b10 release), a log value above 9, or an index of 2^log or more.
- R9: Reset empties the table and clears `rsp_valid`.
- R10: A query never changes the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Request acceptance, always high |
| req_op | input | 2 | 00 query, 01 assign, 10 release, 11 illegal |
| req_log_sf | input | 4 | log2 of the spreading factor |
| req_idx | input | 9 | Code index |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_grant | output | 1 | Request succeeded |
| rsp_conflict | output | 1 | Code clashes with a live entry |
| rsp_full | output | 1 | Assign rejected because no slot is free |
| rsp_error | output | 1 | Malformed request or release miss |
| rsp_slot | output | 3 | Slot that was assigned, released or found blocking |

## Verification
The assertions take two things for granted about the inputs. The request fields hold their values only in a cycle where `req_valid` is high. An opcode read back with `$past` describes the request that the current response answers. The bench meets both conditions: it changes requests only on the falling clock edge and keeps every request to a single cycle. Malformed codes and the illegal opcode are still driven on purpose. The assertions are expected to hold for those too, because such requests leave the table untouched.

// File: rtl/ovsf_pkg.sv
package ovsf_pkg;
  localparam int unsigned LOG_W = 4;
  localparam int unsigned IDX_W = 9;

  typedef enum logic [1:0] {
    OP_QUERY   = 2'd0,
    OP_ASSIGN  = 2'd1,
    OP_RELEASE = 2'd2,
    OP_BAD     = 2'd3
  } ovsf_op_e;

  // True when one code sits on the root path of the other (or they are equal).
  function automatic logic on_root_path(input logic [LOG_W-1:0] la, input logic [IDX_W-1:0] ka,
                                        input logic [LOG_W-1:0] lb, input logic [IDX_W-1:0] kb);
    logic [IDX_W-1:0] trimmed;
    if (la <= lb) begin
      trimmed = kb >> (lb - la);
      return trimmed == ka;
    end
    trimmed = ka >> (la - lb);
    return trimmed == kb;
  endfunction

  // A code is well formed when its depth is supported and its index fits the depth.
  function automatic logic code_ok(input logic [LOG_W-1:0] l, input logic [IDX_W-1:0] k,
                                   input logic [LOG_W-1:0] max_log);
    logic [IDX_W-1:0] upper;
    upper = k >> l;
    return (l <= max_log) && (upper == '0);
  endfunction
endpackage

// File: rtl/ovsf_pair_cmp.sv
module ovsf_pair_cmp
  import ovsf_pkg::*;
(
  input  logic [LOG_W-1:0] ent_log,
  input  logic [IDX_W-1:0] ent_idx,
  input  logic [LOG_W-1:0] req_log,
  input  logic [IDX_W-1:0] req_idx,
  output logic             same_path,
  output logic             same_code
);
  assign same_path = on_root_path(ent_log, ent_idx, req_log, req_idx);
  assign same_code = (ent_log == req_log) && (ent_idx == req_idx);
endmodule

// File: rtl/ovsf_first_set.sv
module ovsf_first_set #(
  parameter int unsigned N = 8,
  localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] bits,
  output logic         found,
  output logic [W-1:0] pos
);
  assign found = |bits;

  always_comb begin
    pos = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (bits[i]) pos = W'(i);
    end
  end
endmodule

// File: rtl/ovsf_tree_guard.sv
module ovsf_tree_guard
  import ovsf_pkg::*;
#(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned MAX_LOG = 9,
  localparam int unsigned SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [LOG_W-1:0]  req_log_sf,
  input  logic [IDX_W-1:0]  req_idx,
  output logic              rsp_valid,
  output logic              rsp_grant,
  output logic              rsp_conflict,
  output logic              rsp_full,
  output logic              rsp_error,
  output logic [SLOT_W-1:0] rsp_slot
);
  // Table storage
  logic [DEPTH-1:0] vld_vec;
  logic [LOG_W-1:0] ent_log [DEPTH];
  logic [IDX_W-1:0] ent_idx [DEPTH];
  logic [CNT_W-1:0] occ_cnt;

  // Parallel comparison against every slot
  logic [DEPTH-1:0] path_vec, code_vec, conf_vec, match_vec;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    ovsf_pair_cmp u_cmp (
      .ent_log   (ent_log[g]),
      .ent_idx   (ent_idx[g]),
      .req_log   (req_log_sf),
      .req_idx   (req_idx),
      .same_path (path_vec[g]),
      .same_code (code_vec[g])
    );
    assign conf_vec[g]  = vld_vec[g] & path_vec[g];
    assign match_vec[g] = vld_vec[g] & code_vec[g];
  end

  logic              conf_found, free_found, match_found;
  logic [SLOT_W-1:0] conf_pos, free_pos, match_pos;

  ovsf_first_set #(.N(DEPTH)) u_pick_conf (.bits(conf_vec),  .found(conf_found),  .pos(conf_pos));
  ovsf_first_set #(.N(DEPTH)) u_pick_free (.bits(~vld_vec),  .found(free_found),  .pos(free_pos));
  ovsf_first_set #(.N(DEPTH)) u_pick_hit  (.bits(match_vec), .found(match_found), .pos(match_pos));

  // Named internal events
  ovsf_op_e op;
  logic     accept, req_legal, ev_assign_ok, ev_release_ok;

  assign req_ready     = 1'b1;
  assign op            = ovsf_op_e'(req_op);
  assign accept        = req_valid && req_ready;
  assign req_legal     = (op != OP_BAD) && code_ok(req_log_sf, req_idx, LOG_W'(MAX_LOG));
  assign ev_assign_ok  = accept && req_legal && (op == OP_ASSIGN) && !conf_found && free_found;
  assign ev_release_ok = accept && req_legal && (op == OP_RELEASE) && match_found;

  // Outcome decision
  logic              nx_grant, nx_conflict, nx_full, nx_error;
  logic [SLOT_W-1:0] nx_slot;

  always_comb begin
    nx_grant    = 1'b0;
    nx_conflict = 1'b0;
    nx_full     = 1'b0;
    nx_error    = 1'b0;
    nx_slot     = '0;
    if (!req_legal) begin
      nx_error = 1'b1;
    end else begin
      case (op)
        OP_QUERY, OP_ASSIGN: begin
          if (conf_found) begin
            nx_conflict = 1'b1;
            nx_slot     = conf_pos;
          end else if (op == OP_ASSIGN && !free_found) begin
            nx_full = 1'b1;
          end else begin
            nx_grant = 1'b1;
            nx_slot  = (op == OP_ASSIGN) ? free_pos : '0;
          end
        end
        OP_RELEASE: begin
          if (match_found) begin
            nx_grant = 1'b1;
            nx_slot  = match_pos;
          end else begin
            nx_error = 1'b1;
          end
        end
        default: nx_error = 1'b1;
      endcase
    end
  end

  // Valid flags and occupancy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_vec <= '0;
      occ_cnt <= '0;
    end else if (ev_assign_ok) begin
      vld_vec[free_pos] <= 1'b1;
      occ_cnt           <= occ_cnt + 1'b1;
    end else if (ev_release_ok) begin
      vld_vec[match_pos] <= 1'b0;
      occ_cnt            <= occ_cnt - 1'b1;
    end
  end

  // Code payload (qualified by the valid flags)
  always_ff @(posedge clk) begin
    if (ev_assign_ok) begin
      ent_log[free_pos] <= req_log_sf;
      ent_idx[free_pos] <= req_idx;
    end
  end

  // Registered response
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_grant    <= 1'b0;
      rsp_conflict <= 1'b0;
      rsp_full     <= 1'b0;
      rsp_error    <= 1'b0;
      rsp_slot     <= '0;
    end else begin
      rsp_valid    <= accept;
      rsp_grant    <= accept && nx_grant;
      rsp_conflict <= accept && nx_conflict;
      rsp_full     <= accept && nx_full;
      rsp_error    <= accept && nx_error;
      rsp_slot     <= accept ? nx_slot : '0;
    end
  end
endmodule

// File: rtl/ovsf_tree_guard_chk.sv
module ovsf_tree_guard_chk #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned SLOT_W = 3,
  parameter int unsigned CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_op,
  input logic              rsp_valid,
  input logic              rsp_grant,
  input logic              rsp_conflict,
  input logic              rsp_full,
  input logic              rsp_error,
  input logic [SLOT_W-1:0] rsp_slot,
  input logic [DEPTH-1:0]  vld_vec,
  input logic [CNT_W-1:0]  occ_cnt
);
  p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_idle_is_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_single_outcome_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_grant, rsp_conflict, rsp_full, rsp_error}) == 1);
  p_assign_adds_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_grant && $past(req_op) == 2'd1) |-> occ_cnt == CNT_W'($past(occ_cnt) + 1'b1));
  p_assign_slot_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_grant && $past(req_op) == 2'd1) |-> vld_vec[rsp_slot]);
  p_conflict_points_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_conflict) |-> vld_vec[rsp_slot]);
  p_conflict_keeps_table_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_conflict) |-> $stable(vld_vec));
  p_full_keeps_table_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_full) |-> ($stable(vld_vec) && occ_cnt == CNT_W'(DEPTH)));
  p_release_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_grant && $past(req_op) == 2'd2) |-> (!vld_vec[rsp_slot] && occ_cnt == CNT_W'($past(occ_cnt) - 1'b1)));
  p_error_keeps_table_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_error) |-> $stable(vld_vec));
  p_count_tracks_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ_cnt) == $countones(vld_vec));
  p_query_keeps_table_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_op) == 2'd0) |-> $stable(vld_vec));
endmodule

bind ovsf_tree_guard ovsf_tree_guard_chk #(
  .DEPTH (DEPTH),
  .SLOT_W(SLOT_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_op       (req_op),
  .rsp_valid    (rsp_valid),
  .rsp_grant    (rsp_grant),
  .rsp_conflict (rsp_conflict),
  .rsp_full     (rsp_full),
  .rsp_error    (rsp_error),
  .rsp_slot     (rsp_slot),
  .vld_vec      (vld_vec),
  .occ_cnt      (occ_cnt)
);

// File: tb/ovsf_tree_guard_tb.sv
module ovsf_tree_guard_tb;
  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_op = 2'd0;
  logic [3:0] req_log_sf = '0;
  logic [8:0] req_idx = '0;
  logic       rsp_valid, rsp_grant, rsp_conflict, rsp_full, rsp_error;
  logic [2:0] rsp_slot;

  always #2.5 clk = ~clk;

  ovsf_tree_guard u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_log_sf(req_log_sf), .req_idx(req_idx),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_conflict(rsp_conflict),
    .rsp_full(rsp_full), .rsp_error(rsp_error), .rsp_slot(rsp_slot)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference table
  bit m_vld [DEPTH];
  int m_log [DEPTH];
  int m_idx [DEPTH];

  function automatic bit tb_clash(int la, int ka, int lb, int kb);
    if (la <= lb) return (kb / (1 << (lb - la))) == ka;
    return (ka / (1 << (la - lb))) == kb;
  endfunction

  task automatic note(bit ok, string tag, string got, string want);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %s expected %s", tag, got, want);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < DEPTH; i++) m_vld[i] = 0;
  endtask

  task automatic run(int op, int l, int k, string tag_in);
    bit eg = 0, ec = 0, ef = 0, ee = 0;
    int es = 0, hit = -1, fr = -1;
    string tag;
    bit legal;
    legal = (op != 3) && (l <= 9) && (k < (1 << l));
    tag = tag_in;
    if (!legal) begin
      ee = 1; if (tag == "") tag = "R8";
    end else if (op == 2) begin
      for (int i = DEPTH - 1; i >= 0; i--)
        if (m_vld[i] && m_log[i] == l && m_idx[i] == k) hit = i;
      if (tag == "") tag = "R7";
      if (hit >= 0) begin eg = 1; es = hit; m_vld[hit] = 0; end
      else ee = 1;
    end else begin
      for (int i = DEPTH - 1; i >= 0; i--) begin
        if (m_vld[i] && tb_clash(m_log[i], m_idx[i], l, k)) hit = i;
        if (!m_vld[i]) fr = i;
      end
      if (hit >= 0) begin
        ec = 1; es = hit; if (tag == "") tag = (op == 0) ? "R2" : "R5";
      end else if (op == 1 && fr < 0) begin
        ef = 1; if (tag == "") tag = "R6";
      end else begin
        eg = 1;
        if (op == 1) begin
          es = fr; m_vld[fr] = 1; m_log[fr] = l; m_idx[fr] = k;
          if (tag == "") tag = "R4";
        end else if (tag == "") tag = "R2";
      end
    end
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_log_sf = 4'(l); req_idx = 9'(k);
    @(negedge clk);
    req_valid = 1'b0;
    note(rsp_valid && rsp_grant == eg && rsp_conflict == ec && rsp_full == ef && rsp_error == ee &&
         (!(eg || ec) || rsp_slot == 3'(es)),
         $sformatf("%s op%0d sf_log%0d idx%0d", tag, op, l, k),
         $sformatf("v%0b g%0b c%0b f%0b e%0b s%0d", rsp_valid, rsp_grant, rsp_conflict, rsp_full, rsp_error, rsp_slot),
         $sformatf("v1 g%0b c%0b f%0b e%0b s%0d", eg, ec, ef, ee, es));
  endtask

  task automatic idle_check();
    @(negedge clk);
    note(!rsp_valid, "R1 idle", $sformatf("v%0b", rsp_valid), "v0");
  endtask

  task automatic sweep(int max_l);
    for (int l = 0; l <= max_l; l++)
      for (int k = 0; k < (1 << l); k++) run(0, l, k, "");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit [15:0] lf;
    model_clear();
    repeat (3) @(negedge clk);
    note(!rsp_valid && req_ready, "R9 reset", $sformatf("v%0b rdy%0b", rsp_valid, req_ready), "v0 rdy1");
    rst_n = 1'b1;
    idle_check();
    sweep(4);                              // empty table grants everything (R9)

    run(1, 2, 1, "R4");                    // SF4 idx1 into slot 0
    run(0, 0, 0, "R3"); run(0, 1, 0, "R3");
    run(0, 3, 2, "R3"); run(0, 3, 3, "R3");
    for (int k = 4; k < 8; k++) run(0, 4, k, "R3");
    run(0, 2, 0, "R3"); run(0, 2, 2, "R3"); run(0, 2, 3, "R3");
    sweep(5);                              // R2 against the reference
    run(2, 2, 0, "R7"); run(2, 1, 0, "R7"); run(2, 3, 2, "R7");
    run(2, 2, 1, "R10");                   // still held after all queries
    idle_check();
    sweep(3);

    for (int k = 0; k < 8; k++) run(1, 3, k, "R4");
    run(1, 3, 0, "R5"); run(1, 4, 9, "R5"); run(1, 9, 511, "R5"); run(1, 0, 0, "R5");
    run(2, 3, 5, "R7");
    run(1, 4, 10, "R4");
    run(1, 4, 11, "R6");                   // free of clash but no slot
    run(1, 5, 20, "R6");                   // clash wins over full
    run(2, 3, 2, "R7"); run(2, 3, 6, "R7");
    run(1, 5, 24, "R4");                   // lowest free slot
    run(3, 2, 0, "R8"); run(1, 10, 0, "R8"); run(0, 2, 4, "R8"); run(2, 9, 512, "R8");
    run(0, 3, 2, "R8");                    // slot still unoccupied

    rst_n = 1'b0; model_clear();
    @(negedge clk);
    note(!rsp_valid, "R9 mid reset", $sformatf("v%0b", rsp_valid), "v0");
    rst_n = 1'b1;
    run(1, 0, 0, "R9");

    lf = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      int op, l, k;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      op = int'(lf[1:0]);
      if (op == 3 && lf[2]) op = 1;
      l = int'(lf[7:4]);
      if (l > 9 && lf[8]) l = l - 6;
      k = int'(lf[15:7]);
      if (lf[3] && l <= 9) k = k % (1 << l);
      if (op == 2 && lf[9] && m_vld[int'(lf[12:10])]) begin
        l = m_log[int'(lf[12:10])]; k = m_idx[int'(lf[12:10])];
      end
      if (op == 0 && lf[11]) op = 2;
      run(op, l, k, "");
      if (n % 50 == 0) idle_check();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule